// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor core. Each cycle it can accept one operation on two byte operands and an external carry bit. From these it produces a byte result and keeps an 8-bit status word. The operations are addition, addition with carry, subtraction, subtraction with borrow, compare, AND, OR, XOR, one's complement, two's-complement negate, increment and decrement.

Instruction decode, the register file and interrupt handling are outside the block. The surrounding core presents an opcode together with a six-bit flag update mask. The mask selects which of the computed flags are written into the status word. The core also drives four strobes that set or clear the two stored bits, the interrupt enable and the bit-copy bit, which the ALU never computes.

Results are registered. A valid operation presented before a rising clock edge appears on `result` and `status` just after that edge. A one-cycle `resWr` pulse accompanies every operation that writes a result.

Top module: `alu_flags_top`

## Requirements
- R1: While `rstN` is low and after its release, before any operation, `result`, `resWr` and `status` are all 0.
- R2: Opcode 0 (add) gives `result` = A+B mod 256 and opcode 1 (add with carry) gives A+B+`carryIn` mod 256. The computed C is the carry out of bit 7 and the computed H is the carry from bit 3 into bit 4.
- R3: Opcode 2 (subtract) gives A-B and opcode 3 (subtract with borrow) gives A-B-`carryIn`, both mod 256. The computed C is 1 when a borrow is needed (unsigned A < B+borrow-in) and the computed H is 1 when the low nibbles need a borrow.
- R4: For an addition V is 1 when both operands have the same bit 7 and the result's bit 7 differs from it. For a subtraction V is 1 when the operands' bit 7 values differ and the result's bit 7 differs from the minuend's.
- R5: The computed N is bit 7 of the computed value and the computed Z is 1 when that 8-bit value is zero. The computed S is the computed N XOR the computed V.
- R6: Opcode 4 (compare) computes every flag exactly as subtract does, leaves `result` unchanged and does not pulse `resWr`.
- R7: Opcodes 5, 6 and 7 give A AND B, A OR B and A XOR B, and opcode 8 gives NOT A. For these four opcodes the computed H, V and C are 0.
- R8: Opcode 9 (negate) is computed as 0-A, opcode 10 (increment) as A+1 and opcode 11 (decrement) as A-1, each with the flag rules of subtraction or addition respectively and no carry-in.
- R9: `flagMask` bit k (0=C, 1=Z, 2=N, 3=V, 4=S, 5=H) allows status bit k to take its computed value. A status bit whose mask bit is 0 keeps its value. Opcodes 12 to 15, and cycles without `opValid`, change neither `result` nor status bits 5..0 and give no `resWr`.
- R10: `setI`/`clrI` set or clear status bit 7 and `setT`/`clrT` set or clear status bit 6. Set wins when both are high. No operation otherwise changes these two bits.
- R11: A valid operation sampled at a rising edge updates `result` and `status` at that edge. It drives `resWr` high for exactly the following cycle when it writes a result.
- R12: The status word holds, from bit 7 down to bit 0: I, T, H, S, V, N, Z, C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 4 | Operation select (0..11 defined) |
| opA | input | 8 | First operand (minuend) |
| opB | input | 8 | Second operand |
| carryIn | input | 1 | Carry or borrow input for opcodes 1 and 3 |
| flagMask | input | 6 | Per-flag update enable, bit k for status bit k |
| setI | input | 1 | Set interrupt-enable bit |
| clrI | input | 1 | Clear interrupt-enable bit |
| setT | input | 1 | Set bit-copy bit |
| clrT | input | 1 | Clear bit-copy bit |
| result | output | 8 | Registered result |
| resWr | output | 1 | One-cycle result-write pulse |
| status | output | 8 | Status word I,T,H,S,V,N,Z,C |

## Verification
Additions are tried with operands that carry only out of the low nibble, with two positives that wrap negative, and with a sum that wraps exactly to zero. These cases separate H from C and V and show Z together with C. Subtractions use a smaller minuend, a negative minus a positive, and equal operands with a borrow in. These cases separate borrow, signed overflow and the carry-in path. Compare with equal operands, negate of 0x00 and 0x80, increment of 0x7F and decrement of 0x00 probe the edges of the shared adder. Partial masks, undefined opcodes and conflicting set/clear strobes show which status bits must hold, and a long pseudo-random run mixes all of these.

// File: rtl/alu_flags_pkg.sv
`timescale 1ns/1ps
package alu_flags_pkg;
  localparam int DATA_W   = 8;
  localparam int HALF_BIT = DATA_W / 2;
  localparam int FLAG_N   = 6;
  localparam int OP_W     = 4;
  localparam int STAT_W   = FLAG_N + 2;
  localparam int I_POS    = STAT_W - 1;
  localparam int T_POS    = STAT_W - 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
    OP_CMP = 4'd4, OP_AND = 4'd5, OP_OR  = 4'd6, OP_XOR = 4'd7,
    OP_COM = 4'd8, OP_NEG = 4'd9, OP_INC = 4'd10, OP_DEC = 4'd11
  } aluOp_e;

  typedef enum logic [1:0] { Y_B = 2'd0, Y_ONE = 2'd1, Y_A = 2'd2 } ySel_e;
  typedef enum logic [1:0] { L_AND = 2'd0, L_OR = 2'd1, L_XOR = 2'd2, L_NOT = 2'd3 } logicOp_e;

  typedef struct packed {
    logic     active;
    logic     writeRes;
    logic     isArith;
    logic     doSub;
    logic     useCin;
    logic     xZero;
    ySel_e    ySel;
    logicOp_e lop;
  } aluCtrl_t;
endpackage

// File: rtl/alu_flags_ctrl.sv
`timescale 1ns/1ps
module alu_flags_ctrl
  import alu_flags_pkg::*;
(
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  output aluCtrl_t        ctrl
);
  always_comb begin
    ctrl = '0;
    if (opValid) begin
      ctrl.active   = 1'b1;
      ctrl.writeRes = 1'b1;
      ctrl.isArith  = 1'b1;
      ctrl.ySel     = Y_B;
      ctrl.lop      = L_AND;
      case (opCode)
        OP_ADD: ;
        OP_ADC: ctrl.useCin = 1'b1;
        OP_SUB: ctrl.doSub = 1'b1;
        OP_SBC: begin
          ctrl.doSub  = 1'b1;
          ctrl.useCin = 1'b1;
        end
        OP_CMP: begin
          ctrl.doSub    = 1'b1;
          ctrl.writeRes = 1'b0;
        end
        OP_AND: ctrl.isArith = 1'b0;
        OP_OR: begin
          ctrl.isArith = 1'b0;
          ctrl.lop     = L_OR;
        end
        OP_XOR: begin
          ctrl.isArith = 1'b0;
          ctrl.lop     = L_XOR;
        end
        OP_COM: begin
          ctrl.isArith = 1'b0;
          ctrl.lop     = L_NOT;
        end
        OP_NEG: begin
          ctrl.doSub = 1'b1;
          ctrl.xZero = 1'b1;
          ctrl.ySel  = Y_A;
        end
        OP_INC: ctrl.ySel = Y_ONE;
        OP_DEC: begin
          ctrl.doSub = 1'b1;
          ctrl.ySel  = Y_ONE;
        end
        default: ctrl = '0;
      endcase
    end
  end
endmodule

// File: rtl/alu_flags_datapath.sv
`timescale 1ns/1ps
module alu_flags_datapath
  import alu_flags_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int HB = HALF_BIT
) (
  input  aluCtrl_t          ctrl,
  input  logic [W-1:0]      opA,
  input  logic [W-1:0]      opB,
  input  logic              carryIn,
  output logic [W-1:0]      aluRes,
  output logic [FLAG_N-1:0] newFlags
);
  logic [W-1:0]  xOp, yOp, logicRes;
  logic [W:0]    wide;
  logic [HB:0]   half;
  logic          cinEff, hF, sF, vF, nF, zF, cF;

  assign xOp    = ctrl.xZero ? '0 : opA;
  assign cinEff = ctrl.useCin & carryIn;

  always_comb begin
    case (ctrl.ySel)
      Y_ONE:   yOp = {{(W-1){1'b0}}, 1'b1};
      Y_A:     yOp = opA;
      default: yOp = opB;
    endcase
  end

  always_comb begin
    if (ctrl.doSub) begin
      wide = {1'b0, xOp} - {1'b0, yOp} - {{W{1'b0}}, cinEff};
      half = {1'b0, xOp[HB-1:0]} - {1'b0, yOp[HB-1:0]} - {{HB{1'b0}}, cinEff};
    end else begin
      wide = {1'b0, xOp} + {1'b0, yOp} + {{W{1'b0}}, cinEff};
      half = {1'b0, xOp[HB-1:0]} + {1'b0, yOp[HB-1:0]} + {{HB{1'b0}}, cinEff};
    end
  end

  always_comb begin
    case (ctrl.lop)
      L_OR:    logicRes = opA | opB;
      L_XOR:   logicRes = opA ^ opB;
      L_NOT:   logicRes = ~opA;
      default: logicRes = opA & opB;
    endcase
  end

  always_comb begin
    if (ctrl.isArith) begin
      aluRes = wide[W-1:0];
      cF     = wide[W];
      hF     = half[HB];
      if (ctrl.doSub)
        vF = (xOp[W-1] != yOp[W-1]) && (wide[W-1] != xOp[W-1]);
      else
        vF = (xOp[W-1] == yOp[W-1]) && (wide[W-1] != xOp[W-1]);
    end else begin
      aluRes = logicRes;
      cF     = 1'b0;
      hF     = 1'b0;
      vF     = 1'b0;
    end
    nF = aluRes[W-1];
    zF = (aluRes == '0);
    sF = nF ^ vF;
  end

  assign newFlags = {hF, sF, vF, nF, zF, cF};
endmodule

// File: rtl/alu_flags_state.sv
`timescale 1ns/1ps
module alu_flags_state
  import alu_flags_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluCtrl_t          ctrl,
  input  logic [W-1:0]      aluRes,
  input  logic [FLAG_N-1:0] newFlags,
  input  logic [FLAG_N-1:0] flagMask,
  input  logic              setI,
  input  logic              clrI,
  input  logic              setT,
  input  logic              clrT,
  output logic [W-1:0]      result,
  output logic              resWr,
  output logic [STAT_W-1:0] status
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      resWr  <= 1'b0;
    end else begin
      resWr <= ctrl.active & ctrl.writeRes;
      if (ctrl.active && ctrl.writeRes)
        result <= aluRes;
    end
  end

  for (genvar k = 0; k < FLAG_N; k++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        status[k] <= 1'b0;
      else if (ctrl.active && flagMask[k])
        status[k] <= newFlags[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status[I_POS] <= 1'b0;
      status[T_POS] <= 1'b0;
    end else begin
      if (setI)      status[I_POS] <= 1'b1;
      else if (clrI) status[I_POS] <= 1'b0;
      if (setT)      status[T_POS] <= 1'b1;
      else if (clrT) status[T_POS] <= 1'b0;
    end
  end
endmodule

// File: rtl/alu_flags_top.sv
`timescale 1ns/1ps
module alu_flags_top
  import alu_flags_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic [FLAG_N-1:0] flagMask,
  input  logic              setI,
  input  logic              clrI,
  input  logic              setT,
  input  logic              clrT,
  output logic [DATA_W-1:0] result,
  output logic              resWr,
  output logic [STAT_W-1:0] status
);
  aluCtrl_t          ctrl;
  logic [DATA_W-1:0] aluRes;
  logic [FLAG_N-1:0] newFlags;

  alu_flags_ctrl u_ctrl (
    .opValid(opValid), .opCode(opCode), .ctrl(ctrl)
  );

  alu_flags_datapath #(.W(DATA_W), .HB(HALF_BIT)) u_dp (
    .ctrl(ctrl), .opA(opA), .opB(opB), .carryIn(carryIn),
    .aluRes(aluRes), .newFlags(newFlags)
  );

  alu_flags_state #(.W(DATA_W)) u_state (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .aluRes(aluRes),
    .newFlags(newFlags), .flagMask(flagMask), .setI(setI), .clrI(clrI),
    .setT(setT), .clrT(clrT), .result(result), .resWr(resWr), .status(status)
  );
endmodule

// File: rtl/alu_flags_chk.sv
`timescale 1ns/1ps
module alu_flags_chk
  import alu_flags_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [OP_W-1:0]   opCode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              carryIn,
  input logic [FLAG_N-1:0] flagMask,
  input logic              setI,
  input logic              clrI,
  input logic              setT,
  input logic              clrT,
  input logic [DATA_W-1:0] result,
  input logic              resWr,
  input logic [STAT_W-1:0] status
);
  logic definedOp, logicOp;
  assign definedOp = opValid && (opCode <= OP_DEC);
  assign logicOp   = opValid && (opCode >= OP_AND) && (opCode <= OP_COM);

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CMP) |=> !resWr); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !definedOp |=> ($stable(status[FLAG_N-1:0]) && $stable(result) && !resWr)); // R9

  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rstN)
    (definedOp && flagMask[4:2] == 3'b111) |=> (status[4] == (status[3] ^ status[2]))); // R5

  AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (definedOp && opCode != OP_CMP && flagMask[1]) |=> (status[1] == (result == '0))); // R5

  AST_LOGIC_NO_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (logicOp && flagMask[3]) |=> !status[3]); // R7

  AST_I_SET: assert property (@(posedge clk) disable iff (!rstN)
    setI |=> status[I_POS]); // R10

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resWr |-> $past(opValid)); // R11
endmodule

bind alu_flags_top alu_flags_chk u_chk (.*);

// File: tb/sim_alu_flags_top.sv
`timescale 1ns/1ps
module sim_alu_flags_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opCode = '0;
  logic [7:0] opA = '0, opB = '0;
  logic       carryIn = 1'b0;
  logic [5:0] flagMask = '0;
  logic       setI = 1'b0, clrI = 1'b0, setT = 1'b0, clrT = 1'b0;
  logic [7:0] result;
  logic       resWr;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] res;
    logic       wr;
    logic [7:0] st;
    string      tag;
  } expItem_t;

  expItem_t   sbQ[$];
  logic [7:0] expRes = '0;
  logic [7:0] expSt  = '0;

  always #5 clk = ~clk;

  alu_flags_top u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opA(opA),
    .opB(opB), .carryIn(carryIn), .flagMask(flagMask), .setI(setI),
    .clrI(clrI), .setT(setT), .clrT(clrT), .result(result), .resWr(resWr),
    .status(status)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic vld, input logic [3:0] op, input logic [7:0] a,
                      input logic [7:0] b, input logic ci, input logic [5:0] m,
                      input logic sI, input logic cI, input logic sT, input logic cT,
                      input string tag);
    logic [7:0] xb, yb, r;
    int         c, full;
    logic       h, v, cy, isW, isF;
    logic [5:0] nf;
    expItem_t   it;
    @(negedge clk);
    opValid = vld; opCode = op; opA = a; opB = b; carryIn = ci; flagMask = m;
    setI = sI; clrI = cI; setT = sT; clrT = cT;
    isW = vld; isF = vld; h = 0; v = 0; cy = 0; r = expRes; c = 0;
    if (vld) begin
      case (op)
        4'd0, 4'd1, 4'd10: begin
          xb = a; yb = (op == 4'd10) ? 8'd1 : b; c = (op == 4'd1) ? int'(ci) : 0;
          full = int'(xb) + int'(yb) + c;
          r  = full[7:0];
          cy = full > 255;
          h  = (int'(xb[3:0]) + int'(yb[3:0]) + c) > 15;
          v  = (xb[7] == yb[7]) && (r[7] != xb[7]);
        end
        4'd2, 4'd3, 4'd4, 4'd9, 4'd11: begin
          xb = (op == 4'd9) ? 8'd0 : a;
          yb = (op == 4'd9) ? a : (op == 4'd11) ? 8'd1 : b;
          c  = (op == 4'd3) ? int'(ci) : 0;
          full = int'(xb) - int'(yb) - c;
          r  = full[7:0];
          cy = full < 0;
          h  = (int'(xb[3:0]) - int'(yb[3:0]) - c) < 0;
          v  = (xb[7] != yb[7]) && (r[7] != xb[7]);
          if (op == 4'd4) isW = 0;
        end
        4'd5: r = a & b;
        4'd6: r = a | b;
        4'd7: r = a ^ b;
        4'd8: r = ~a;
        default: begin isW = 0; isF = 0; end
      endcase
    end
    nf = {h, r[7] ^ v, v, r[7], (r == 8'd0), cy};
    if (isW) expRes = r;
    for (int k = 0; k < 6; k++)
      if (isF && m[k]) expSt[k] = nf[k];
    if (sI) expSt[7] = 1'b1; else if (cI) expSt[7] = 1'b0;
    if (sT) expSt[6] = 1'b1; else if (cT) expSt[6] = 1'b0;
    it.res = expRes; it.wr = isW; it.st = expSt; it.tag = tag;
    sbQ.push_back(it);
  endtask

  // monitor: compares each captured operation 2 ns after the edge that registered it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sbQ.size() > 0) begin
        expItem_t e;
        e = sbQ.pop_front();
        check({result, resWr, status} == {e.res, e.wr, e.st}, e.tag,
              {15'd0, result, resWr, status}, {15'd0, e.res, e.wr, e.st});
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    #12;
    check({result, resWr, status} == 17'd0, "R1 outputs in reset", {15'd0, result, resWr, status}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #2;
    check({result, resWr, status} == 17'd0, "R1 outputs after reset", {15'd0, result, resWr, status}, 32'd0);

    doOp(1, 4'd0, 8'h3A, 8'h28, 0, 6'h3F, 0, 0, 0, 0, "R2 add nibble carry");
    doOp(1, 4'd0, 8'h7F, 8'h01, 0, 6'h3F, 0, 0, 0, 0, "R4 add positive overflow");
    doOp(1, 4'd0, 8'hFF, 8'h01, 0, 6'h3F, 0, 0, 0, 0, "R2 R5 add wrap to zero");
    doOp(1, 4'd1, 8'h10, 8'h20, 1, 6'h3F, 0, 0, 0, 0, "R2 add with carry");
    doOp(1, 4'd2, 8'h10, 8'h20, 0, 6'h3F, 0, 0, 0, 0, "R3 subtract borrow");
    doOp(1, 4'd2, 8'h80, 8'h01, 0, 6'h3F, 0, 0, 0, 0, "R4 subtract overflow");
    doOp(1, 4'd3, 8'h05, 8'h05, 1, 6'h3F, 0, 0, 0, 0, "R3 subtract with borrow in");
    doOp(1, 4'd4, 8'h42, 8'h42, 0, 6'h3F, 0, 0, 0, 0, "R6 compare equal");
    doOp(1, 4'd4, 8'h01, 8'h02, 0, 6'h3F, 0, 0, 0, 0, "R6 compare less");
    doOp(1, 4'd5, 8'hF0, 8'h3C, 0, 6'h3F, 0, 0, 0, 0, "R7 and");
    doOp(1, 4'd6, 8'h81, 8'h02, 0, 6'h3F, 0, 0, 0, 0, "R7 or");
    doOp(1, 4'd7, 8'hAA, 8'hAA, 0, 6'h3F, 0, 0, 0, 0, "R7 xor");
    doOp(1, 4'd8, 8'h55, 8'h00, 0, 6'h3F, 0, 0, 0, 0, "R7 complement");
    doOp(1, 4'd9, 8'h00, 8'h00, 0, 6'h3F, 0, 0, 0, 0, "R8 negate zero");
    doOp(1, 4'd9, 8'h80, 8'h00, 0, 6'h3F, 0, 0, 0, 0, "R8 negate 0x80");
    doOp(1, 4'd10, 8'h7F, 8'h00, 0, 6'h3F, 0, 0, 0, 0, "R8 increment 0x7F");
    doOp(1, 4'd11, 8'h00, 8'h00, 0, 6'h3F, 0, 0, 0, 0, "R8 decrement zero");
    doOp(1, 4'd0, 8'hFF, 8'h01, 0, 6'h01, 0, 0, 0, 0, "R9 mask carry only");
    doOp(1, 4'd2, 8'h00, 8'h01, 0, 6'h00, 0, 0, 0, 0, "R9 empty mask");
    doOp(1, 4'd12, 8'h12, 8'h34, 0, 6'h3F, 0, 0, 0, 0, "R9 undefined opcode");
    doOp(0, 4'd0, 8'h12, 8'h34, 0, 6'h3F, 0, 0, 0, 0, "R9 R11 idle cycle");
    doOp(1, 4'd5, 8'h00, 8'h00, 0, 6'h3F, 1, 0, 1, 0, "R10 set I and T with op");
    doOp(1, 4'd0, 8'h01, 8'h01, 0, 6'h3F, 1, 1, 0, 1, "R10 set wins, clear T");
    doOp(0, 4'd0, 8'h00, 8'h00, 0, 6'h00, 0, 1, 0, 0, "R10 R12 clear I layout");

    lfsr = 32'h1D2C3B4A;
    for (int n = 0; n < 400; n++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      doOp(lfsr[31:29] != 3'd0, lfsr[3:0], lfsr[11:4], lfsr[19:12], lfsr[20],
           (lfsr[21] ? 6'h3F : lfsr[27:22]), lfsr[28] & lfsr[2], lfsr[28] & ~lfsr[2],
           lfsr[29] & lfsr[1], lfsr[29] & ~lfsr[1], "R5 R11 random mix");
    end
    doOp(0, 4'd0, 8'h00, 8'h00, 0, 6'h00, 0, 0, 0, 0, "R11 final idle");
    @(posedge clk); #4;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule